// File: doc/BRIEF.md
# Host Bus LED and Input Register Block

This block is a small slave on a parallel host bus. It connects a host to a row of sixteen discrete indicator LEDs, eight slide switches and five pushbuttons. The host sees a 6-bit address bus, an 8-bit bidirectional data bus and three active-low strobes: select, write and output enable. Two 8-bit storage registers hold the LED pattern. Each LED is wired as a current sink, so its pin is driven low to light it. The block inverts the stored bits on the way out, which means a host that writes a 1 turns that LED on.

Reads are combinational from the strobes and the address. Offset 0x00 returns the switches and offset 0x01 returns the pushbuttons. Offsets 0x04 and 0x05 return the two LED registers, and every other offset returns zero. The block drives the data bus only during a qualified read. At all other times the bus is left to the host. Writes are synchronous to a clock that the host supplies. The reset input is asynchronous. Its assertion takes effect at once, and its release is synchronised to the clock.

Top module: `bus_led_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, both LED registers hold 0x00. All sixteen `led_n_o` pins are then high (every LED off), and reads of 0x04 and 0x05 return 0x00.
- R2: On a rising clock edge with `cs_n`=0, `we_n`=0 and address 0x04, the register captures the data bus. `led_n_o[7:0]` then equals the bitwise inverse of the captured byte, so bit n lights LED n.
- R3: On a rising clock edge with `cs_n`=0, `we_n`=0 and address 0x05, the second register captures the data bus. `led_n_o[15:8]` then equals the bitwise inverse of the captured byte.
- R4: A write cycle has no effect on `led_n_o` if `cs_n` is high or if the full 6-bit address is neither 0x04 nor 0x05 (for example 0x06 or 0x24). At most one register is written per edge.
- R5: A read (`cs_n`=0, `oe_n`=0, `we_n`=1) of address 0x00 places the eight switch levels on the data bus, with switch n on bit n.
- R6: A read of address 0x01 returns the five pushbutton levels in bits 4..0 and zeros in bits 7..5.
- R7: A read of 0x04 or 0x05 returns the byte last written to that register, not its inverted pin levels.
- R8: A read of any address other than 0x00, 0x01, 0x04 and 0x05 returns 0x00.
- R9: The block drives the data bus only while `cs_n`=0, `oe_n`=0 and `we_n`=1. Otherwise its outputs are high-impedance, so a write with `oe_n` also low still captures the host's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock supplied by the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register offset |
| bus_data | inout | 8 | Bidirectional data bus |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| sw_i | input | 8 | Slide switch levels |
| btn_i | input | 5 | Pushbutton levels |
| led_n_o | output | 16 | Active-low LED sink drives |

## Verification
The embedded properties assume the host holds address, data and strobes steady across each rising clock edge. They also assume the host never drives the data bus while the block is allowed to drive it. The bench therefore changes every input only on falling edges. It releases its own bus drive before any read cycle and drives the bus only in write or idle cycles. This keeps the sampled write byte clean and the bus free of contention. The bench takes read results combinationally, one nanosecond after it sets the strobes. It checks LED pins on the falling edge that follows the capturing rising edge.

// File: rtl/bus_regs_pkg.sv
package bus_regs_pkg;

  // Source selected for the read data path
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_BTN  = 2'd2,
    SRC_LED  = 2'd3
  } rd_src_e;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bus_decode.sv
module bus_decode
  import bus_regs_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int SW_ADDR  = 0,
  parameter int BTN_ADDR = 1,
  parameter int LED_BASE = 4,
  parameter int LED_REGS = 2,
  localparam int IDX_W   = (LED_REGS > 1) ? $clog2(LED_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                cs_n,
  input  logic                we_n,
  input  logic                oe_n,
  output logic [LED_REGS-1:0] wr_sel,
  output rd_src_e             rd_src,
  output logic [IDX_W-1:0]    led_idx,
  output logic                drv_en
);

  logic wr_en;

  assign wr_en  = !cs_n && !we_n;
  assign drv_en = !cs_n && !oe_n && we_n;

  genvar k;
  generate
    for (k = 0; k < LED_REGS; k++) begin : g_wsel
      assign wr_sel[k] = wr_en && (addr == ADDR_W'(LED_BASE + k));
    end
  endgenerate

  always_comb begin
    rd_src  = SRC_NONE;
    led_idx = '0;
    if (addr == ADDR_W'(SW_ADDR)) begin
      rd_src = SRC_SW;
    end else if (addr == ADDR_W'(BTN_ADDR)) begin
      rd_src = SRC_BTN;
    end else begin
      for (int i = 0; i < LED_REGS; i++) begin
        if (addr == ADDR_W'(LED_BASE + i)) begin
          rd_src  = SRC_LED;
          led_idx = IDX_W'(i);
        end
      end
    end
  end

  // R4
  write_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R9
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_sel) |-> !drv_en);

endmodule

// File: rtl/led_bank.sv
module led_bank #(
  parameter int DATA_W   = 8,
  parameter int LED_REGS = 2,
  localparam int TOT_W   = DATA_W * LED_REGS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LED_REGS-1:0] wr_sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [TOT_W-1:0]    q
);

  logic [TOT_W-1:0] q_nxt;

  genvar k;
  generate
    for (k = 0; k < LED_REGS; k++) begin : g_reg
      always_comb begin
        q_nxt[k*DATA_W +: DATA_W] = q[k*DATA_W +: DATA_W];
        if (wr_sel[k]) begin
          q_nxt[k*DATA_W +: DATA_W] = wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q[k*DATA_W +: DATA_W] <= '0;
        end else if (wr_sel[k]) begin
          q[k*DATA_W +: DATA_W] <= q_nxt[k*DATA_W +: DATA_W];
        end
      end

      // R2
      capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[k] |=> (q[k*DATA_W +: DATA_W] == $past(wdata)));

      // R4
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel[k] |=> $stable(q[k*DATA_W +: DATA_W]));
    end
  endgenerate

endmodule

// File: rtl/rd_mux.sv
module rd_mux
  import bus_regs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SW_W     = 8,
  parameter int BTN_W    = 5,
  parameter int LED_REGS = 2,
  localparam int IDX_W   = (LED_REGS > 1) ? $clog2(LED_REGS) : 1,
  localparam int TOT_W   = DATA_W * LED_REGS
) (
  input  rd_src_e           rd_src,
  input  logic [IDX_W-1:0]  led_idx,
  input  logic [SW_W-1:0]   sw,
  input  logic [BTN_W-1:0]  btn,
  input  logic [TOT_W-1:0]  led_q,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    unique case (rd_src)
      SRC_SW:   rdata = DATA_W'(sw);
      SRC_BTN:  rdata = DATA_W'(btn);
      SRC_LED:  rdata = led_q[led_idx*DATA_W +: DATA_W];
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/bus_led_regfile.sv
module bus_led_regfile
  import bus_regs_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int SW_W     = 8,
  parameter int BTN_W    = 5,
  parameter int LED_REGS = 2,
  parameter int SW_ADDR  = 0,
  parameter int BTN_ADDR = 1,
  parameter int LED_BASE = 4,
  localparam int IDX_W   = (LED_REGS > 1) ? $clog2(LED_REGS) : 1,
  localparam int LED_W   = DATA_W * LED_REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [SW_W-1:0]   sw_i,
  input  logic [BTN_W-1:0]  btn_i,
  output logic [LED_W-1:0]  led_n_o
);

  logic                rst_sync_n;
  logic [LED_REGS-1:0] wr_sel;
  rd_src_e             rd_src;
  logic [IDX_W-1:0]    led_idx;
  logic                drv_en;
  logic [LED_W-1:0]    led_q;
  logic [DATA_W-1:0]   rd_data;

  rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bus_decode #(
    .ADDR_W   (ADDR_W),
    .SW_ADDR  (SW_ADDR),
    .BTN_ADDR (BTN_ADDR),
    .LED_BASE (LED_BASE),
    .LED_REGS (LED_REGS)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr    (bus_addr),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .wr_sel  (wr_sel),
    .rd_src  (rd_src),
    .led_idx (led_idx),
    .drv_en  (drv_en)
  );

  led_bank #(
    .DATA_W   (DATA_W),
    .LED_REGS (LED_REGS)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_sel (wr_sel),
    .wdata  (bus_data),
    .q      (led_q)
  );

  rd_mux #(
    .DATA_W   (DATA_W),
    .SW_W     (SW_W),
    .BTN_W    (BTN_W),
    .LED_REGS (LED_REGS)
  ) u_mux (
    .rd_src  (rd_src),
    .led_idx (led_idx),
    .sw      (sw_i),
    .btn     (btn_i),
    .led_q   (led_q),
    .rdata   (rd_data)
  );

  assign bus_data = drv_en ? rd_data : {DATA_W{1'bz}};
  assign led_n_o  = ~led_q;

  // R1
  reset_dark_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (led_n_o == {LED_W{1'b1}}));

  // R5
  switch_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (drv_en && (bus_addr == ADDR_W'(SW_ADDR))) |-> (rd_data == DATA_W'(sw_i)));

  // R6
  button_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (drv_en && (bus_addr == ADDR_W'(BTN_ADDR))) |-> (rd_data == DATA_W'(btn_i)));

endmodule

// File: tb/tb_bus_led_regfile.sv
module tb_bus_led_regfile;

  logic        clk;
  logic        rst_n;
  logic [5:0]  addr;
  wire  [7:0]  bus;
  logic [7:0]  tb_data;
  logic        tb_drv;
  logic        cs_n, we_n, oe_n;
  logic [7:0]  sw;
  logic [4:0]  btn;
  logic [15:0] led_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  assign bus = tb_drv ? tb_data : 8'hzz;

  bus_led_regfile dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (addr),
    .bus_data (bus),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .sw_i     (sw),
    .btn_i    (btn),
    .led_n_o  (led_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {write, addr, data, sw, btn, expected}
  localparam logic [43:0] VEC [12] = '{
    {1'b1, 6'h04, 8'h3C, 8'hA5, 5'h13, 16'hFFC3},
    {1'b1, 6'h05, 8'h81, 8'hA5, 5'h13, 16'h7EC3},
    {1'b0, 6'h04, 8'h00, 8'hA5, 5'h13, 16'h003C},
    {1'b0, 6'h05, 8'h00, 8'hA5, 5'h13, 16'h0081},
    {1'b0, 6'h00, 8'h00, 8'hA5, 5'h13, 16'h00A5},
    {1'b0, 6'h01, 8'h00, 8'hA5, 5'h13, 16'h0013},
    {1'b0, 6'h01, 8'h00, 8'h00, 5'h1F, 16'h001F},
    {1'b0, 6'h02, 8'h00, 8'hFF, 5'h1F, 16'h0000},
    {1'b0, 6'h3F, 8'h00, 8'hFF, 5'h1F, 16'h0000},
    {1'b1, 6'h06, 8'hFF, 8'hA5, 5'h13, 16'h7EC3},
    {1'b1, 6'h24, 8'hFF, 8'hA5, 5'h13, 16'h7EC3},
    {1'b0, 6'h00, 8'h00, 8'h5A, 5'h00, 16'h005A}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d, input logic sel_n, input logic oe_low);
    @(negedge clk);
    addr = a; tb_data = d; tb_drv = 1'b1;
    cs_n = sel_n; we_n = 1'b0; oe_n = !oe_low;
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tb_drv = 1'b0;
    #1;
  endtask

  task automatic do_read(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    tb_drv = 1'b0; addr = a;
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    #1;
    d = bus;
    @(negedge clk);
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [43:0] v;
    string tag;
    rst_n = 1'b0; addr = '0; tb_data = '0; tb_drv = 1'b0;
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; sw = 8'hA5; btn = 5'h13;
    repeat (3) @(negedge clk);
    #1;
    check("R1 leds during reset", led_n, 16'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 leds after reset", led_n, 16'hFFFF);
    do_read(6'h04, rd);
    check("R1 reg 0x04 after reset", {8'h00, rd}, 16'h0000);
    do_read(6'h05, rd);
    check("R1 reg 0x05 after reset", {8'h00, rd}, 16'h0000);

    for (int i = 0; i < 12; i++) begin
      v   = VEC[i];
      sw  = v[28:21];
      btn = v[20:16];
      if (v[43]) begin
        tag = (v[42:37] == 6'h04) ? "R2" : (v[42:37] == 6'h05) ? "R3" : "R4";
        do_write(v[42:37], v[36:29], 1'b0, 1'b0);
        check($sformatf("%s table write %0d", tag, i), led_n, v[15:0]);
      end else begin
        case (v[42:37])
          6'h00:        tag = "R5";
          6'h01:        tag = "R6";
          6'h04, 6'h05: tag = "R7";
          default:      tag = "R8";
        endcase
        do_read(v[42:37], rd);
        check($sformatf("%s table read %0d", tag, i), {8'h00, rd}, v[15:0]);
      end
    end

    // R4: deselected write leaves LEDs alone
    do_write(6'h04, 8'h00, 1'b1, 1'b0);
    check("R4 write with cs_n high", led_n, 16'h7EC3);

    // R9: output enable low during a write must not block capture
    do_write(6'h04, 8'h5A, 1'b0, 1'b1);
    check("R9 write with oe_n low", led_n, 16'h7EA5);
    do_read(6'h04, rd);
    check("R9 readback after oe_n-low write", {8'h00, rd}, 16'h005A);

    // R1: reset during operation clears at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", led_n, 16'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(6'h05, rd);
    check("R1 reg 0x05 after mid-run reset", {8'h00, rd}, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule